// File: doc/BRIEF.md
# Dual-Bank Sample Pipeline Controller

This block buffers the samples of one readout channel in two banks of 48 cells each, for a low-gain path and a high-gain path. On every bunch-crossing strobe both 12-bit samples go into the bank that is currently writing. The write pointer runs round the 48 cells and keeps going across bank swaps. A superbunch strobe swaps the writing and reading roles of the two banks. A bank is therefore never written while it is being read.

A level-1 accept picks the trigger cell. That cell lies a programmable number of crossings behind the write pointer, in the reading bank. The block also picks the cell three crossings before it as the baseline. It then emits the difference, trigger minus baseline, as a signed 13-bit value. The low-gain result comes out first and the high-gain result follows one cycle later. An accept that arrives during a readout is queued in a single holding slot. A swap request that arrives during a readout is held back until the reader is idle.

Top module: `sbpipe_top`

## Requirements
- R1: After reset `busy`, `writeBank`, both valid strobes and both difference outputs are 0.
- R2: Each clock edge with `xingStb` high stores `sampleLo` and `sampleHi` at the write pointer of the bank selected by `writeBank`. The pointer then advances 0,1,…,47,0 and is not reset by a bank swap.
- R3: A `superStb` at an edge where `busy` is low and `l1Accept` is low toggles `writeBank` at that edge. Readouts always use the bank not selected by `writeBank`.
- R4: The trigger cell is (P − L) mod 48. P is the write pointer (the next cell to be written) at the accept edge and L is the value of `latency` at that edge (1..47; larger values act as 47).
- R5: The baseline cell is (trigger − 3) mod 48 in the same bank. Each output is trigger sample minus baseline sample as 13-bit two's complement, covering −4095..+4095.
- R6: For an accept taken at edge k, `busy` is high from edge k to edge k+2. `diffLoValid` is high for exactly the cycle after edge k+1 and `diffHiValid` for exactly the cycle after edge k+2.
- R7: An accept seen while busy, with the holding slot empty, is queued with its cell addresses fixed at its own edge. Its readout starts at the edge that ends the current one, with no idle cycle in between.
- R8: An accept seen while busy, with the holding slot already full, is dropped and produces no readout.
- R9: A `superStb` seen while busy is deferred and takes effect at the first edge at which the reader is idle. `writeBank` never changes at an edge that closes a busy cycle. The bank being read is never written during a readout.
- R10: `diffLoValid` and `diffHiValid` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| xingStb | input | 1 | Crossing strobe: store one sample pair |
| superStb | input | 1 | Superbunch strobe: swap bank roles |
| l1Accept | input | 1 | Level-1 accept |
| latency | input | 6 | Trigger latency in crossings |
| sampleLo | input | 12 | Low-gain sample |
| sampleHi | input | 12 | High-gain sample |
| busy | output | 1 | Readout in progress |
| writeBank | output | 1 | Bank currently written (the other is read) |
| diffLo | output | 13 | Low-gain trigger minus baseline, signed |
| diffLoValid | output | 1 | One-cycle strobe for `diffLo` |
| diffHi | output | 13 | High-gain trigger minus baseline, signed |
| diffHiValid | output | 1 | One-cycle strobe for `diffHi` |

## Verification
Every result has a fixed latency measured from the edge that samples its cause:
- `busy` is visible one edge after an accept.
- The low-gain difference is due after the second edge and the high-gain difference after the third.
- A queued event adds exactly two more edges.
- A deferred swap shows up one edge after the readout ends.

The bench drives inputs on falling edges and counts rising edges to the cycle in which each output is due. It samples on the next falling edge and checks the neighbouring cycles for silence. The expected differences come from a bench-side model of both banks and the write pointer. Latency is swept across every value, so every trigger cell, including the wrapped baselines, gets read.

// File: rtl/sbpipe_pkg.sv
package sbpipe_pkg;

  localparam int unsigned CELLS    = 48;
  localparam int unsigned SAMP_W   = 12;
  localparam int unsigned BASE_LAG = 3;
  localparam int unsigned GAINS    = 2;
  localparam int unsigned PTR_W    = $clog2(CELLS);
  localparam int unsigned DIFF_W   = SAMP_W + 1;

  typedef logic [PTR_W-1:0] cell_t;

  localparam cell_t            LAST_CELL = cell_t'(CELLS - 1);
  localparam cell_t            LAG_CELL  = cell_t'(BASE_LAG);
  localparam logic [PTR_W:0]   CELLS_X   = (PTR_W + 1)'(CELLS);

  typedef enum logic [1:0] {
    RD_IDLE = 2'd0,
    RD_LOW  = 2'd1,
    RD_HIGH = 2'd2
  } rd_state_t;

  typedef struct packed {
    logic  wrEn;
    logic  wrBank;
    cell_t wrAddr;
    logic  rdEn;
    logic  rdHigh;
    logic  rdBank;
    cell_t rdTrig;
    cell_t rdBase;
  } pipe_ctl_t;

  // Circular subtraction over the cell ring; back must be below CELLS.
  function automatic cell_t cellBack(input cell_t from, input cell_t back);
    logic [PTR_W:0] sum;
    sum = {1'b0, from} + CELLS_X - {1'b0, back};
    if (sum >= CELLS_X) sum = sum - CELLS_X;
    return sum[PTR_W-1:0];
  endfunction

endpackage

// File: rtl/sbpipe_control.sv
module sbpipe_control
  import sbpipe_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             xingStb,
  input  logic             superStb,
  input  logic             l1Accept,
  input  logic [PTR_W-1:0] latency,
  output pipe_ctl_t        ctl,
  output logic             busy,
  output logic             writeBank
);

  rd_state_t state, stateNext;

  cell_t wrPtr;
  logic  wrBankQ;
  logic  swapPending;

  logic  curBank;
  cell_t curTrig, curBase;

  logic  holdValid;
  logic  holdBank;
  cell_t holdTrig, holdBase;

  cell_t latEff;
  cell_t acceptTrig, acceptBase;
  logic  acceptBank;

  logic startIdle, chainNew, useHold, queueNew;
  logic swapReq, swapNow;

  // Cell addresses an accept would use if taken at this edge
  always_comb begin
    latEff     = (latency > LAST_CELL) ? LAST_CELL : latency;
    acceptTrig = cellBack(wrPtr, latEff);
    acceptBase = cellBack(acceptTrig, LAG_CELL);
    acceptBank = ~wrBankQ;
  end

  always_comb begin
    startIdle = (state == RD_IDLE) && l1Accept;
    chainNew  = (state == RD_HIGH) && l1Accept && !holdValid;
    useHold   = (state == RD_HIGH) && holdValid;
    queueNew  = (state == RD_LOW)  && l1Accept && !holdValid;
    swapReq   = superStb || swapPending;
    swapNow   = swapReq && (state == RD_IDLE) && !l1Accept;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      RD_IDLE: stateNext = l1Accept ? RD_LOW : RD_IDLE;
      RD_LOW:  stateNext = RD_HIGH;
      RD_HIGH: stateNext = (holdValid || l1Accept) ? RD_LOW : RD_IDLE;
      default: stateNext = RD_IDLE;
    endcase
  end

  // Readout sequencer and holding slot
  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= RD_IDLE;
      curBank   <= 1'b0;
      curTrig   <= '0;
      curBase   <= '0;
      holdValid <= 1'b0;
      holdBank  <= 1'b0;
      holdTrig  <= '0;
      holdBase  <= '0;
    end else begin
      state <= stateNext;
      if (startIdle || chainNew) begin
        curBank <= acceptBank;
        curTrig <= acceptTrig;
        curBase <= acceptBase;
      end else if (useHold) begin
        curBank <= holdBank;
        curTrig <= holdTrig;
        curBase <= holdBase;
      end
      if (queueNew) begin
        holdValid <= 1'b1;
        holdBank  <= acceptBank;
        holdTrig  <= acceptTrig;
        holdBase  <= acceptBase;
      end else if (useHold) begin
        holdValid <= 1'b0;
      end
    end
  end

  // Write pointer and bank role
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr       <= '0;
      wrBankQ     <= 1'b0;
      swapPending <= 1'b0;
    end else begin
      if (xingStb) wrPtr <= (wrPtr == LAST_CELL) ? '0 : wrPtr + cell_t'(1);
      if (swapNow) wrBankQ <= ~wrBankQ;
      swapPending <= swapReq && !swapNow;
    end
  end

  always_comb begin
    ctl.wrEn   = xingStb;
    ctl.wrBank = wrBankQ;
    ctl.wrAddr = wrPtr;
    ctl.rdEn   = (state != RD_IDLE);
    ctl.rdHigh = (state == RD_HIGH);
    ctl.rdBank = curBank;
    ctl.rdTrig = curTrig;
    ctl.rdBase = curBase;
  end

  assign busy      = (state != RD_IDLE);
  assign writeBank = wrBankQ;

endmodule

// File: rtl/sbpipe_datapath.sv
module sbpipe_datapath
  import sbpipe_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  pipe_ctl_t                ctl,
  input  logic [SAMP_W-1:0]        sampleIn [GAINS],
  output logic signed [DIFF_W-1:0] diffOut  [GAINS],
  output logic [GAINS-1:0]         diffValid
);

  for (genvar g = 0; g < GAINS; g++) begin : g_path
    localparam bit IS_HIGH = (g == GAINS - 1);

    logic [SAMP_W-1:0]        bankMem [2][CELLS];
    logic [SAMP_W-1:0]        trigVal, baseVal;
    logic signed [DIFF_W-1:0] trigS, baseS;
    logic                     pick;

    always_ff @(posedge clk) begin
      if (ctl.wrEn) bankMem[ctl.wrBank][ctl.wrAddr] <= sampleIn[g];
    end

    always_comb begin
      trigVal = bankMem[ctl.rdBank][ctl.rdTrig];
      baseVal = bankMem[ctl.rdBank][ctl.rdBase];
      trigS   = $signed({1'b0, trigVal});
      baseS   = $signed({1'b0, baseVal});
      pick    = ctl.rdEn && (ctl.rdHigh == IS_HIGH);
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        diffOut[g]   <= '0;
        diffValid[g] <= 1'b0;
      end else begin
        diffValid[g] <= pick;
        if (pick) diffOut[g] <= trigS - baseS;
      end
    end
  end

endmodule

// File: rtl/sbpipe_top.sv
module sbpipe_top
  import sbpipe_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     xingStb,
  input  logic                     superStb,
  input  logic                     l1Accept,
  input  logic [PTR_W-1:0]         latency,
  input  logic [SAMP_W-1:0]        sampleLo,
  input  logic [SAMP_W-1:0]        sampleHi,
  output logic                     busy,
  output logic                     writeBank,
  output logic signed [DIFF_W-1:0] diffLo,
  output logic                     diffLoValid,
  output logic signed [DIFF_W-1:0] diffHi,
  output logic                     diffHiValid
);

  pipe_ctl_t                ctlBus;
  logic [SAMP_W-1:0]        sampleArr [GAINS];
  logic signed [DIFF_W-1:0] diffArr   [GAINS];
  logic [GAINS-1:0]         validArr;

  assign sampleArr[0] = sampleLo;
  assign sampleArr[1] = sampleHi;

  sbpipe_control u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .xingStb   (xingStb),
    .superStb  (superStb),
    .l1Accept  (l1Accept),
    .latency   (latency),
    .ctl       (ctlBus),
    .busy      (busy),
    .writeBank (writeBank)
  );

  sbpipe_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctlBus),
    .sampleIn  (sampleArr),
    .diffOut   (diffArr),
    .diffValid (validArr)
  );

  assign diffLo      = diffArr[0];
  assign diffHi      = diffArr[1];
  assign diffLoValid = validArr[0];
  assign diffHiValid = validArr[1];

endmodule

// File: rtl/sbpipe_checker.sv
module sbpipe_checker
  import sbpipe_pkg::*;
(
  input logic      clk,
  input logic      rstN,
  input logic      superStb,
  input logic      l1Accept,
  input logic      busy,
  input logic      writeBank,
  input logic      diffLoValid,
  input logic      diffHiValid,
  input pipe_ctl_t ctl
);

  a_r6_hi_follows_lo: assert property (@(posedge clk) disable iff (!rstN)
    diffLoValid |=> diffHiValid);

  a_r6_accept_busy: assert property (@(posedge clk) disable iff (!rstN)
    (l1Accept && !busy) |=> busy);

  a_r10_one_path: assert property (@(posedge clk) disable iff (!rstN)
    !(diffLoValid && diffHiValid));

  a_r9_swap_held: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(writeBank));

  a_r3_idle_swap: assert property (@(posedge clk) disable iff (!rstN)
    (superStb && !busy && !l1Accept) |=> (writeBank != $past(writeBank)));

  a_r9_no_clash: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.rdEn && ctl.wrEn) |-> (ctl.wrBank != ctl.rdBank));

endmodule

bind sbpipe_top sbpipe_checker u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .superStb    (superStb),
  .l1Accept    (l1Accept),
  .busy        (busy),
  .writeBank   (writeBank),
  .diffLoValid (diffLoValid),
  .diffHiValid (diffHiValid),
  .ctl         (ctlBus)
);

// File: tb/tb_sbpipe_top.sv
module tb_sbpipe_top;

  logic               clk = 1'b0;
  logic               rstN;
  logic               xingStb, superStb, l1Accept;
  logic [5:0]         latency;
  logic [11:0]        sampleLo, sampleHi;
  logic               busy, writeBank;
  logic signed [12:0] diffLo, diffHi;
  logic               diffLoValid, diffHiValid;

  int nRun  = 0;
  int nFail = 0;
  int mdl [2][2][48];
  int mwb  = 0;
  int mptr = 0;

  always #2 clk = ~clk;

  sbpipe_top dut (
    .clk(clk), .rstN(rstN), .xingStb(xingStb), .superStb(superStb),
    .l1Accept(l1Accept), .latency(latency), .sampleLo(sampleLo),
    .sampleHi(sampleHi), .busy(busy), .writeBank(writeBank),
    .diffLo(diffLo), .diffLoValid(diffLoValid), .diffHi(diffHi),
    .diffHiValid(diffHiValid)
  );

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  function automatic int expDiff(input int g, input int lat);
    int rb, t, b;
    rb = 1 - mwb;
    t  = (mptr - lat + 96) % 48;
    b  = (t - 3 + 48) % 48;
    return mdl[g][rb][t] - mdl[g][rb][b];
  endfunction

  // R2: one sample pair stored at the model pointer of the write bank
  task automatic crossing(input int lo, input int hi);
    xingStb  = 1'b1;
    sampleLo = 12'(lo);
    sampleHi = 12'(hi);
    @(negedge clk);
    xingStb = 1'b0;
    mdl[0][mwb][mptr] = lo;
    mdl[1][mwb][mptr] = hi;
    mptr = (mptr + 1) % 48;
  endtask

  task automatic swapIdle();
    superStb = 1'b1;
    @(negedge clk);
    superStb = 1'b0;
    mwb = 1 - mwb;
    chk(writeBank == 1'(mwb), "R3 idle swap", int'(writeBank), mwb);
  endtask

  task automatic trigger(input int lat);
    int eLo, eHi;
    eLo = expDiff(0, lat);
    eHi = expDiff(1, lat);
    latency  = 6'(lat);
    l1Accept = 1'b1;
    @(negedge clk);
    l1Accept = 1'b0;
    chk(busy == 1'b1, "R6 busy after accept", int'(busy), 1);
    chk(diffLoValid == 1'b0, "R6 lo not yet valid", int'(diffLoValid), 0);
    @(negedge clk);
    chk(diffLoValid == 1'b1, "R6 lo valid", int'(diffLoValid), 1);
    chk(int'(diffLo) == eLo, "R2 R4 R5 lo diff", int'(diffLo), eLo);
    chk(diffHiValid == 1'b0, "R10 hi quiet", int'(diffHiValid), 0);
    @(negedge clk);
    chk(diffHiValid == 1'b1, "R6 hi valid", int'(diffHiValid), 1);
    chk(int'(diffHi) == eHi, "R2 R4 R5 hi diff", int'(diffHi), eHi);
    chk(diffLoValid == 1'b0, "R6 lo single cycle", int'(diffLoValid), 0);
    chk(busy == 1'b0, "R6 busy released", int'(busy), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    int e1Lo, e1Hi, e2Lo, e2Hi, eLo, eHi;
    rstN = 1'b0; xingStb = 1'b0; superStb = 1'b0; l1Accept = 1'b0;
    latency = '0; sampleLo = '0; sampleHi = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(busy == 1'b0, "R1 busy", int'(busy), 0);
    chk(writeBank == 1'b0, "R1 writeBank", int'(writeBank), 0);
    chk(diffLoValid == 1'b0 && diffHiValid == 1'b0, "R1 valids",
        int'({diffLoValid, diffHiValid}), 0);
    chk(diffLo == 0, "R1 diffLo", int'(diffLo), 0);
    chk(diffHi == 0, "R1 diffHi", int'(diffHi), 0);

    // Fill bank 0 completely; pointer wraps back to 0 (R2)
    for (int i = 0; i < 48; i++) begin
      int lo, hi;
      lo = (i * 173 + 11) % 4096;
      hi = (i * 59 + 3000) % 4096;
      if (i == 5) lo = 4095;
      if (i == 2) lo = 0;
      if (i == 10) hi = 0;
      if (i == 7) hi = 4095;
      crossing(lo, hi);
    end
    swapIdle();

    // R5 extremes: trigger cell 5 / 10 with baselines 2 / 7
    trigger(43);
    trigger(38);

    // R4 sweep of every latency, writing the other bank in between
    for (int lat = 1; lat < 48; lat++) begin
      trigger(lat);
      crossing((lat * 31 + 7) % 4096, (lat * 97 + 1234) % 4096);
    end
    // R4 out-of-range latency acts as 47
    eLo = expDiff(0, 47);
    trigger(47);
    latency = 6'd60;
    l1Accept = 1'b1;
    @(negedge clk); l1Accept = 1'b0;
    @(negedge clk);
    chk(int'(diffLo) == eLo, "R4 latency clamp", int'(diffLo), eLo);
    @(negedge clk);

    // R7 / R8: queued accept then a dropped one
    e1Lo = expDiff(0, 4);  e1Hi = expDiff(1, 4);
    e2Lo = expDiff(0, 9);  e2Hi = expDiff(1, 9);
    latency = 6'd4; l1Accept = 1'b1;
    @(negedge clk);                  // edge k
    latency = 6'd9;                  // second accept at k+1, queued
    @(negedge clk);                  // edge k+1
    chk(diffLoValid == 1'b1 && int'(diffLo) == e1Lo, "R7 first lo", int'(diffLo), e1Lo);
    latency = 6'd20;                 // third accept at k+2, dropped
    @(negedge clk);                  // edge k+2
    l1Accept = 1'b0;
    chk(diffHiValid == 1'b1 && int'(diffHi) == e1Hi, "R7 first hi", int'(diffHi), e1Hi);
    chk(busy == 1'b1, "R7 no idle gap", int'(busy), 1);
    @(negedge clk);                  // edge k+3
    chk(diffLoValid == 1'b1 && int'(diffLo) == e2Lo, "R7 queued lo", int'(diffLo), e2Lo);
    @(negedge clk);                  // edge k+4
    chk(diffHiValid == 1'b1 && int'(diffHi) == e2Hi, "R7 queued hi", int'(diffHi), e2Hi);
    chk(busy == 1'b0, "R8 no third readout busy", int'(busy), 0);
    @(negedge clk);
    chk(diffLoValid == 1'b0, "R8 dropped accept lo", int'(diffLoValid), 0);
    @(negedge clk);
    chk(diffHiValid == 1'b0 && busy == 1'b0, "R8 dropped accept hi",
        int'({diffHiValid, busy}), 0);

    // R9: swap requested during readout is deferred
    eLo = expDiff(0, 6); eHi = expDiff(1, 6);
    latency = 6'd6; l1Accept = 1'b1;
    @(negedge clk);                  // edge k
    l1Accept = 1'b0; superStb = 1'b1;
    xingStb = 1'b1; sampleLo = 12'd77; sampleHi = 12'd88;
    @(negedge clk);                  // edge k+1: swap seen while busy
    superStb = 1'b0; xingStb = 1'b0;
    mdl[0][mwb][mptr] = 77; mdl[1][mwb][mptr] = 88; mptr = (mptr + 1) % 48;
    chk(writeBank == 1'(mwb), "R9 no swap while busy", int'(writeBank), mwb);
    chk(int'(diffLo) == eLo, "R9 read bank intact lo", int'(diffLo), eLo);
    @(negedge clk);                  // edge k+2
    chk(int'(diffHi) == eHi, "R9 read bank intact hi", int'(diffHi), eHi);
    chk(writeBank == 1'(mwb), "R9 no swap at release", int'(writeBank), mwb);
    @(negedge clk);                  // edge k+3
    mwb = 1 - mwb;
    chk(writeBank == 1'(mwb), "R9 deferred swap applied", int'(writeBank), mwb);

    // Read the other bank now (R3), writing into the new write bank
    for (int lat = 2; lat < 48; lat += 5) begin
      trigger(lat);
      crossing((lat * 211) % 4096, (lat * 13 + 4000) % 4096);
    end

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule